// File: doc/BRIEF.md
# Console I/O Port Address Decoder

This block sits between an 8-bit CPU's I/O cycle and the peripherals of a retro game console family. It decodes the 8-bit I/O port address of each read or write. It raises one select for the addressed peripheral and steers that peripheral's read data back to the CPU. The peripherals are the memory-control register, the I/O-control register, the sound generator, the video chip (data/control and beam counters), the controller ports, the FM sound unit and the serial link. Decoding is partial: most ports look only at address bits 7, 6 and 0. A system-mode input applies overrides on top of that decode for the home console, the handheld, the handheld running in compatibility mode, and the older video-chip systems.

The block holds the memory-control register itself and drives slot-enable outputs from it for the bank mapper. It also models open-bus reads. The opcode byte from the most recent instruction fetch is latched. An unmapped read returns that byte with a pull-up mask ORed in and a pull-down mask cleared out.

Top module: `cons_io_decode`

## Requirements
- R1: In home-console mode (mode 0), writes decode on port AND 0xC1. 0x00 selects memory control and 0x01 selects I/O control. 0x40 and 0x41 select sound, 0x80 and 0x81 select video, and 0xC0 and 0xC1 select nothing.
- R2: In home-console mode, write port 0xF0 selects the FM address, 0xF1 the FM data and 0xF2 the FM detect latch. These three override the masked decode.
- R3: In home-console mode, reads decode on port AND 0xC0. 0x00 gives open bus, 0x40 the beam counters, 0x80 the video chip and 0xC0 the controllers. A read of 0xF2 instead selects FM detect and returns FM detect data AND controller data.
- R4: In handheld mode (1) and handheld-compatibility mode (2), every port at or below 0x20 goes to the serial link for reads and writes, ahead of the masked decode. Above 0x20, writes decode as in R1 except that 0xC0/0xC1 select nothing.
- R5: In both handheld modes, reads above 0x20 decode as in R3 with two exceptions. In the 0xC0 group only ports 0xC0, 0xC1, 0xDC and 0xDD select the controllers, and every other port in that group gives open bus. Port 0xF2 has no FM meaning.
- R6: In legacy-video mode (3), writes with port AND 0xC0 equal to 0x40 select sound and 0x80 select video, and all other writes select nothing. Reads select video at 0x80 and controllers at 0xC0, and return 0xFF everywhere else.
- R7: An open-bus read returns (L OR pull-up) AND NOT pull-down. L is the byte on cpu_din at the last clock edge with m1_fetch high, and resets to 0x00.
- R8: The memory-control register resets to 0x00 and loads wr_data on the edge after a memory-control write select. cart_en is the inverse of register bit 6 and bios_en the inverse of bit 3, so 0x48 disables both.
- R9: Every select is combinational and is high only while its strobe is high. At most one select is high at a time. When rd_stb and wr_stb are both high, only the write decode acts.
- R10: vdp_hh_fmt is high exactly in handheld mode (1), telling the video chip to use handheld write format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_mode | input | 2 | 0 home console, 1 handheld, 2 handheld compatibility, 3 legacy video |
| port_addr | input | 8 | I/O port address (low byte) |
| rd_stb | input | 1 | I/O read strobe |
| wr_stb | input | 1 | I/O write strobe |
| wr_data | input | 8 | Write data from CPU |
| m1_fetch | input | 1 | Opcode fetch cycle marker |
| cpu_din | input | 8 | CPU data bus, sampled on fetch |
| ob_pullup | input | 8 | Open-bus pull-up mask |
| ob_pulldown | input | 8 | Open-bus pull-down mask |
| vcnt_rdata | input | 8 | Beam counter read data |
| vdp_rdata | input | 8 | Video chip read data |
| pad_rdata | input | 8 | Controller port read data |
| fmdet_rdata | input | 8 | FM detect latch read data |
| ser_rdata | input | 8 | Serial link read data |
| cpu_rdata | output | 8 | Read data to CPU |
| sel_memctl_wr | output | 1 | Memory-control register write |
| sel_ioctl_wr | output | 1 | I/O-control register write |
| sel_psg_wr | output | 1 | Sound generator write |
| sel_vdp_wr | output | 1 | Video chip write |
| sel_fm_addr_wr | output | 1 | FM unit address write |
| sel_fm_data_wr | output | 1 | FM unit data write |
| sel_fmdet_wr | output | 1 | FM detect latch write |
| sel_ser_wr | output | 1 | Serial link write |
| sel_vdp_rd | output | 1 | Video chip read |
| sel_vcnt_rd | output | 1 | Beam counter read |
| sel_pad_rd | output | 1 | Controller port read |
| sel_fmdet_rd | output | 1 | FM detect read |
| sel_ser_rd | output | 1 | Serial link read |
| memctl_q | output | 8 | Memory-control register value |
| cart_en | output | 1 | Cartridge slot enabled |
| bios_en | output | 1 | BIOS slot enabled |
| vdp_hh_fmt | output | 1 | Handheld video format select |

## Verification
Every one of the 256 port addresses is tried in all four modes, once as a read, once as a write and once with both strobes high. The bench compares the full select vector against a model written from range and bit tests rather than masks. This tells apart the partial decode, the exact-match controller ports, the serial window boundary at 0x20/0x21 and the FM override at 0xF0 to 0xF2. The sweep runs twice, with different peripheral data, latched opcodes and pull masks, so that each read source and the open-bus formula cannot be mistaken for another. Directed writes of 0x00, 0x08, 0x40 and 0x48 to the memory-control register check each slot-enable combination. A write attempted in legacy-video mode checks that the register is left unchanged.

// File: rtl/cons_io_pkg.sv
package cons_io_pkg;

    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        SYS_HOME       = 2'd0,
        SYS_HANDHELD   = 2'd1,
        SYS_HH_COMPAT  = 2'd2,
        SYS_LEGACY_VID = 2'd3
    } sys_mode_e;

    localparam logic [PORT_W-1:0] PORT_FM_ADDR  = 8'hF0;
    localparam logic [PORT_W-1:0] PORT_FM_DATA  = 8'hF1;
    localparam logic [PORT_W-1:0] PORT_FM_DET   = 8'hF2;
    localparam logic [PORT_W-1:0] SERIAL_LAST   = 8'h20;
    localparam logic [PORT_W-1:0] WR_GROUP_MASK = 8'hC1;

    typedef struct packed {
        logic memctl;
        logic ioctl;
        logic psg;
        logic vdp;
        logic fm_addr;
        logic fm_data;
        logic fm_det;
        logic serial;
    } wr_sel_t;

    // Read source: device selects plus two non-device sources
    typedef struct packed {
        logic vdp;
        logic vcnt;
        logic pad;
        logic fm_det;
        logic serial;
        logic open_bus;
        logic float_hi;
    } rd_src_t;

    function automatic logic is_handheld(input sys_mode_e m);
        return (m == SYS_HANDHELD) || (m == SYS_HH_COMPAT);
    endfunction

    function automatic logic is_pad_exact(input logic [PORT_W-1:0] p);
        return (p == 8'hC0) || (p == 8'hC1) || (p == 8'hDC) || (p == 8'hDD);
    endfunction

endpackage

// File: rtl/cons_io_wdec.sv
module cons_io_wdec
    import cons_io_pkg::*;
(
    input  sys_mode_e           mode,
    input  logic [PORT_W-1:0]   port,
    input  logic                wr_en,
    output wr_sel_t             sel
);
    logic [PORT_W-1:0] grp;
    assign grp = port & WR_GROUP_MASK;

    always_comb begin
        sel = '0;
        if (wr_en) begin
            unique case (mode)
                SYS_HOME: begin
                    if (port == PORT_FM_ADDR)      sel.fm_addr = 1'b1;
                    else if (port == PORT_FM_DATA) sel.fm_data = 1'b1;
                    else if (port == PORT_FM_DET)  sel.fm_det  = 1'b1;
                    else begin
                        case (grp)
                            8'h00:        sel.memctl = 1'b1;
                            8'h01:        sel.ioctl  = 1'b1;
                            8'h40, 8'h41: sel.psg    = 1'b1;
                            8'h80, 8'h81: sel.vdp    = 1'b1;
                            default:      ;
                        endcase
                    end
                end
                SYS_HANDHELD, SYS_HH_COMPAT: begin
                    if (port <= SERIAL_LAST) sel.serial = 1'b1;
                    else begin
                        case (grp)
                            8'h00:        sel.memctl = 1'b1;
                            8'h01:        sel.ioctl  = 1'b1;
                            8'h40, 8'h41: sel.psg    = 1'b1;
                            8'h80, 8'h81: sel.vdp    = 1'b1;
                            default:      ;
                        endcase
                    end
                end
                default: begin
                    case (port[7:6])
                        2'b01:   sel.psg = 1'b1;
                        2'b10:   sel.vdp = 1'b1;
                        default: ;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/cons_io_rdec.sv
module cons_io_rdec
    import cons_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  sys_mode_e           mode,
    input  logic [PORT_W-1:0]   port,
    input  logic [DATA_W-1:0]   open_bus,
    input  logic [DATA_W-1:0]   vcnt_rdata,
    input  logic [DATA_W-1:0]   vdp_rdata,
    input  logic [DATA_W-1:0]   pad_rdata,
    input  logic [DATA_W-1:0]   fmdet_rdata,
    input  logic [DATA_W-1:0]   ser_rdata,
    output rd_src_t             src,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        src = '0;
        unique case (mode)
            SYS_HOME: begin
                if (port == PORT_FM_DET) src.fm_det = 1'b1;
                else begin
                    unique case (port[7:6])
                        2'b00: src.open_bus = 1'b1;
                        2'b01: src.vcnt     = 1'b1;
                        2'b10: src.vdp      = 1'b1;
                        2'b11: src.pad      = 1'b1;
                    endcase
                end
            end
            SYS_HANDHELD, SYS_HH_COMPAT: begin
                if (port <= SERIAL_LAST) src.serial = 1'b1;
                else begin
                    unique case (port[7:6])
                        2'b00: src.open_bus = 1'b1;
                        2'b01: src.vcnt     = 1'b1;
                        2'b10: src.vdp      = 1'b1;
                        2'b11: begin
                            if (is_pad_exact(port)) src.pad      = 1'b1;
                            else                    src.open_bus = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                case (port[7:6])
                    2'b10:   src.vdp      = 1'b1;
                    2'b11:   src.pad      = 1'b1;
                    default: src.float_hi = 1'b1;
                endcase
            end
        endcase
    end

    always_comb begin
        rdata = '1;
        if (src.vdp)           rdata = vdp_rdata;
        else if (src.vcnt)     rdata = vcnt_rdata;
        else if (src.pad)      rdata = pad_rdata;
        else if (src.fm_det)   rdata = fmdet_rdata & pad_rdata;
        else if (src.serial)   rdata = ser_rdata;
        else if (src.open_bus) rdata = open_bus;
    end
endmodule

// File: rtl/cons_io_state.sv
module cons_io_state #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              memctl_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              m1_fetch,
    input  logic [DATA_W-1:0] cpu_din,
    input  logic [DATA_W-1:0] ob_pullup,
    input  logic [DATA_W-1:0] ob_pulldown,
    output logic [DATA_W-1:0] memctl_q,
    output logic              cart_en,
    output logic              bios_en,
    output logic [DATA_W-1:0] open_bus
);
    localparam int CART_OFF_BIT = 6;
    localparam int BIOS_OFF_BIT = 3;

    logic [DATA_W-1:0] last_op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            memctl_q  <= '0;
            last_op_q <= '0;
        end else begin
            if (memctl_we) memctl_q  <= wr_data;
            if (m1_fetch)  last_op_q <= cpu_din;
        end
    end

    assign cart_en  = ~memctl_q[CART_OFF_BIT];
    assign bios_en  = ~memctl_q[BIOS_OFF_BIT];
    assign open_bus = (last_op_q | ob_pullup) & ~ob_pulldown;

    // R8: a write of the "neither slot" code turns both slots off
    p_slot_off_r8: assert property (@(posedge clk) disable iff (rst)
        memctl_we && wr_data[CART_OFF_BIT] && wr_data[BIOS_OFF_BIT]
        |=> !cart_en && !bios_en);

    // R8: without a write select the register holds
    p_memctl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !memctl_we |=> $stable(memctl_q));

    // R7: latched opcode shows through when no mask bits are set
    p_ob_follow_r7: assert property (@(posedge clk) disable iff (rst)
        m1_fetch && ob_pullup == '0 && ob_pulldown == '0
        |=> ($past(ob_pullup) != ob_pullup || $past(ob_pulldown) != ob_pulldown)
            || open_bus == $past(cpu_din));
endmodule

// File: rtl/cons_io_decode.sv
module cons_io_decode
    import cons_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sys_mode,
    input  logic [7:0]        port_addr,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              m1_fetch,
    input  logic [DATA_W-1:0] cpu_din,
    input  logic [DATA_W-1:0] ob_pullup,
    input  logic [DATA_W-1:0] ob_pulldown,
    input  logic [DATA_W-1:0] vcnt_rdata,
    input  logic [DATA_W-1:0] vdp_rdata,
    input  logic [DATA_W-1:0] pad_rdata,
    input  logic [DATA_W-1:0] fmdet_rdata,
    input  logic [DATA_W-1:0] ser_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              sel_memctl_wr,
    output logic              sel_ioctl_wr,
    output logic              sel_psg_wr,
    output logic              sel_vdp_wr,
    output logic              sel_fm_addr_wr,
    output logic              sel_fm_data_wr,
    output logic              sel_fmdet_wr,
    output logic              sel_ser_wr,
    output logic              sel_vdp_rd,
    output logic              sel_vcnt_rd,
    output logic              sel_pad_rd,
    output logic              sel_fmdet_rd,
    output logic              sel_ser_rd,
    output logic [DATA_W-1:0] memctl_q,
    output logic              cart_en,
    output logic              bios_en,
    output logic              vdp_hh_fmt
);
    sys_mode_e         mode;
    wr_sel_t           wsel;
    rd_src_t           rsrc;
    logic              rd_en;
    logic [DATA_W-1:0] open_bus;

    assign mode  = sys_mode_e'(sys_mode);
    assign rd_en = rd_stb & ~wr_stb;

    cons_io_wdec u_wdec (
        .mode  (mode),
        .port  (port_addr),
        .wr_en (wr_stb),
        .sel   (wsel)
    );

    cons_io_rdec #(.DATA_W(DATA_W)) u_rdec (
        .mode        (mode),
        .port        (port_addr),
        .open_bus    (open_bus),
        .vcnt_rdata  (vcnt_rdata),
        .vdp_rdata   (vdp_rdata),
        .pad_rdata   (pad_rdata),
        .fmdet_rdata (fmdet_rdata),
        .ser_rdata   (ser_rdata),
        .src         (rsrc),
        .rdata       (cpu_rdata)
    );

    cons_io_state #(.DATA_W(DATA_W)) u_state (
        .clk         (clk),
        .rst         (rst),
        .memctl_we   (wsel.memctl),
        .wr_data     (wr_data),
        .m1_fetch    (m1_fetch),
        .cpu_din     (cpu_din),
        .ob_pullup   (ob_pullup),
        .ob_pulldown (ob_pulldown),
        .memctl_q    (memctl_q),
        .cart_en     (cart_en),
        .bios_en     (bios_en),
        .open_bus    (open_bus)
    );

    assign sel_memctl_wr  = wsel.memctl;
    assign sel_ioctl_wr   = wsel.ioctl;
    assign sel_psg_wr     = wsel.psg;
    assign sel_vdp_wr     = wsel.vdp;
    assign sel_fm_addr_wr = wsel.fm_addr;
    assign sel_fm_data_wr = wsel.fm_data;
    assign sel_fmdet_wr   = wsel.fm_det;
    assign sel_ser_wr     = wsel.serial;
    assign sel_vdp_rd     = rd_en & rsrc.vdp;
    assign sel_vcnt_rd    = rd_en & rsrc.vcnt;
    assign sel_pad_rd     = rd_en & rsrc.pad;
    assign sel_fmdet_rd   = rd_en & rsrc.fm_det;
    assign sel_ser_rd     = rd_en & rsrc.serial;

    assign vdp_hh_fmt = (mode == SYS_HANDHELD);

    logic [12:0] all_sel;
    assign all_sel = {sel_memctl_wr, sel_ioctl_wr, sel_psg_wr, sel_vdp_wr,
                      sel_fm_addr_wr, sel_fm_data_wr, sel_fmdet_wr, sel_ser_wr,
                      sel_vdp_rd, sel_vcnt_rd, sel_pad_rd, sel_fmdet_rd, sel_ser_rd};

    // R9: never two selects at once
    p_onehot_sel_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_sel));

    // R9: write selects only under the write strobe
    p_wr_needs_stb_r9: assert property (@(posedge clk) disable iff (rst)
        (|all_sel[12:5]) |-> wr_stb);

    // R9: read selects only under a lone read strobe
    p_rd_needs_stb_r9: assert property (@(posedge clk) disable iff (rst)
        (|all_sel[4:0]) |-> rd_stb && !wr_stb);

    // R6: legacy mode low half of the map floats high
    p_legacy_float_r6: assert property (@(posedge clk) disable iff (rst)
        sys_mode == 2'd3 && !port_addr[7] |-> cpu_rdata == '1);

    // R6: legacy mode never loads the memory-control register
    p_legacy_no_memctl_r6: assert property (@(posedge clk) disable iff (rst)
        sys_mode == 2'd3 |-> !sel_memctl_wr);

    // R4: serial window owns both directions in handheld modes
    p_serial_window_r4: assert property (@(posedge clk) disable iff (rst)
        (sys_mode == 2'd1 || sys_mode == 2'd2) && port_addr <= 8'h20 && wr_stb
        |-> sel_ser_wr);
endmodule

// File: tb/cons_io_decode_tb.sv
module cons_io_decode_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sys_mode;
    logic [7:0] port_addr, wr_data, cpu_din, ob_pullup, ob_pulldown;
    logic [7:0] vcnt_rdata, vdp_rdata, pad_rdata, fmdet_rdata, ser_rdata;
    logic       rd_stb, wr_stb, m1_fetch;
    logic [7:0] cpu_rdata, memctl_q;
    logic       sel_memctl_wr, sel_ioctl_wr, sel_psg_wr, sel_vdp_wr;
    logic       sel_fm_addr_wr, sel_fm_data_wr, sel_fmdet_wr, sel_ser_wr;
    logic       sel_vdp_rd, sel_vcnt_rd, sel_pad_rd, sel_fmdet_rd, sel_ser_rd;
    logic       cart_en, bios_en, vdp_hh_fmt;

    int n_checks = 0;
    int n_err    = 0;
    logic [7:0] op_model;

    always #4 clk = ~clk;

    cons_io_decode dut_i (.*);

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // select order: memctl ioctl psg vdpw fma fmd fmdetw serw | vdpr vcnt pad fmdetr serr
    function automatic logic [12:0] model_sel(input int m, input int p,
                                              input bit rd, input bit wr);
        logic [12:0] s = '0;
        int hi = p / 64;
        bit odd = (p % 2) == 1;
        if (wr) begin
            if (m == 0) begin
                if (p == 240) s[8] = 1;
                else if (p == 241) s[7] = 1;
                else if (p == 242) s[6] = 1;
                else if (hi == 0) s[odd ? 11 : 12] = 1;
                else if (hi == 1) s[10] = 1;
                else if (hi == 2) s[9] = 1;
            end else if (m == 3) begin
                if (hi == 1) s[10] = 1;
                else if (hi == 2) s[9] = 1;
            end else begin
                if (p < 33) s[5] = 1;
                else if (hi == 0) s[odd ? 11 : 12] = 1;
                else if (hi == 1) s[10] = 1;
                else if (hi == 2) s[9] = 1;
            end
        end else if (rd) begin
            if (m == 0) begin
                if (p == 242) s[1] = 1;
                else if (hi == 1) s[3] = 1;
                else if (hi == 2) s[4] = 1;
                else if (hi == 3) s[2] = 1;
            end else if (m == 3) begin
                if (hi == 2) s[4] = 1;
                else if (hi == 3) s[2] = 1;
            end else begin
                if (p < 33) s[0] = 1;
                else if (hi == 1) s[3] = 1;
                else if (hi == 2) s[4] = 1;
                else if (p == 192 || p == 193 || p == 220 || p == 221) s[2] = 1;
            end
        end
        return s;
    endfunction

    function automatic logic [7:0] model_rdata(input int m, input int p);
        int hi = p / 64;
        logic [7:0] ob = (op_model | ob_pullup) & ~ob_pulldown;
        if (m == 3) return (hi == 2) ? vdp_rdata : (hi == 3) ? pad_rdata : 8'hFF;
        if (m == 0) begin
            if (p == 242) return fmdet_rdata & pad_rdata;
        end else begin
            if (p < 33) return ser_rdata;
            if (hi == 3 && !(p == 192 || p == 193 || p == 220 || p == 221)) return ob;
        end
        case (hi)
            0: return ob;
            1: return vcnt_rdata;
            2: return vdp_rdata;
            default: return pad_rdata;
        endcase
    endfunction

    function automatic string sel_tag(input int m, input int p, input bit rd_only);
        if (m == 3) return "R6";
        if (m == 0) begin
            if (p >= 240 && p <= 242) return rd_only ? "R3" : "R2";
            return rd_only ? "R3" : "R1";
        end
        if (p < 33) return "R4";
        return rd_only ? "R5" : "R4";
    endfunction

    function automatic logic [12:0] got_sel();
        return {sel_memctl_wr, sel_ioctl_wr, sel_psg_wr, sel_vdp_wr,
                sel_fm_addr_wr, sel_fm_data_wr, sel_fmdet_wr, sel_ser_wr,
                sel_vdp_rd, sel_vcnt_rd, sel_pad_rd, sel_fmdet_rd, sel_ser_rd};
    endfunction

    task automatic fetch_op(input logic [7:0] b);
        @(negedge clk);
        m1_fetch = 1'b1; cpu_din = b;
        @(negedge clk);
        m1_fetch = 1'b0; cpu_din = 8'h00;
        op_model = b;
    endtask

    task automatic sweep();
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 256; p++) begin
                sys_mode = 2'(m); port_addr = 8'(p);
                rd_stb = 1; wr_stb = 0; #1;
                check(sel_tag(m, p, 1), "read sel", 32'(got_sel()), 32'(model_sel(m, p, 1, 0)));
                check(m == 3 ? "R6" : (m == 0 ? "R3" : "R5"), "rdata",
                      32'(cpu_rdata), 32'(model_rdata(m, p)));
                rd_stb = 0; wr_stb = 1; #1;
                check(sel_tag(m, p, 0), "write sel", 32'(got_sel()), 32'(model_sel(m, p, 0, 1)));
                rd_stb = 1; #1;
                check("R9", "both strobes", 32'(got_sel()), 32'(model_sel(m, p, 1, 1)));
                rd_stb = 0; wr_stb = 0; #1;
                check("R9", "idle sel", 32'(got_sel()), 32'd0);
            end
        end
    endtask

    task automatic mc_write(input logic [1:0] m, input logic [7:0] d);
        @(negedge clk);
        sys_mode = m; port_addr = 8'h3E; wr_data = d; wr_stb = 1;
        @(negedge clk);
        wr_stb = 0;
    endtask

    initial begin
        rst = 1; sys_mode = 0; port_addr = 0; rd_stb = 0; wr_stb = 0; wr_data = 0;
        m1_fetch = 0; cpu_din = 0; ob_pullup = 0; ob_pulldown = 0;
        vcnt_rdata = 8'h11; vdp_rdata = 8'h22; pad_rdata = 8'h5C;
        fmdet_rdata = 8'h0F; ser_rdata = 8'h33; op_model = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        check("R8", "reset memctl", 32'(memctl_q), 32'h00);
        check("R8", "reset slots", 32'({cart_en, bios_en}), 32'b11);
        check("R7", "reset open bus", 32'(cpu_rdata), 32'h00);

        for (int m = 0; m < 4; m++) begin
            sys_mode = 2'(m); #1;
            check("R10", "hh format", 32'(vdp_hh_fmt), 32'(m == 1));
        end

        // pattern A: opcode A5, no masks
        fetch_op(8'hA5);
        sweep();

        // pattern B: new data, masks both active
        @(negedge clk);
        vcnt_rdata = 8'hC3; vdp_rdata = 8'h9A; pad_rdata = 8'hF7;
        fmdet_rdata = 8'h63; ser_rdata = 8'h48;
        ob_pullup = 8'h0C; ob_pulldown = 8'h81;
        fetch_op(8'h3A);
        sweep();

        // open bus directed: (3A|0C)&~81 = 3E
        sys_mode = 0; port_addr = 8'h10; rd_stb = 1; #1;
        check("R7", "open bus mask", 32'(cpu_rdata), 32'h3E);
        rd_stb = 0;
        fetch_op(8'hFF);
        ob_pullup = 8'h00; ob_pulldown = 8'h00;
        port_addr = 8'h3F; rd_stb = 1; #1;
        check("R7", "open bus new opcode", 32'(cpu_rdata), 32'hFF);
        rd_stb = 0;

        // memory control register slots
        mc_write(2'd0, 8'h08); #1;
        check("R8", "0x08 value", 32'(memctl_q), 32'h08);
        check("R8", "0x08 slots", 32'({cart_en, bios_en}), 32'b10);
        mc_write(2'd1, 8'h40); #1;
        check("R8", "0x40 slots", 32'({cart_en, bios_en}), 32'b01);
        mc_write(2'd0, 8'h48); #1;
        check("R8", "0x48 slots", 32'({cart_en, bios_en}), 32'b00);
        mc_write(2'd3, 8'h00); #1;
        check("R6", "legacy no memctl load", 32'(memctl_q), 32'h48);
        mc_write(2'd2, 8'h00); #1;
        check("R8", "0x00 slots", 32'({cart_en, bios_en}), 32'b11);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule